// File: doc/BRIEF.md
# Serial Bus Clock Generator with Delayed Data Strobe

This block derives a two-wire serial bus clock from the controller's system clock and tells the protocol logic when it may move the data line and when it should read it. An 8-bit divider sets the length of each half of the bus clock in system clocks. A 3-bit delay places the data-update strobe a set number of system clocks after every falling bus-clock edge. This keeps changes on the data line clear of the clock transition. A sample strobe marks every rising edge.

The protocol sequencer raises `run_en` for as long as it needs bus activity. The bus clock starts with a falling edge on the first system-clock edge that sees `run_en` high. While the generator is idle it holds the bus clock high. Divider and delay values are captured only while idle, so a new setting can never disturb a transfer that is under way.

Top module: `busclk_gen`

## Requirements
- R1: While `rst_n` is low, `bus_clk` is 1 and `upd_stb` and `smp_stb` are 0.
- R2: While the generator is idle (`run_en` low), `bus_clk` stays 1 and both strobes stay 0, whatever `div_cfg` and `dly_cfg` do.
- R3: On the first rising system-clock edge with `run_en` high after idle, `bus_clk` goes to 0; that edge starts the first low half.
- R4: While running, `bus_clk` stays low for `div_cfg`+1 system clocks, then high for `div_cfg`+1 system clocks, and repeats. The period is 2×(`div_cfg`+1), so a divider of 255 gives system clock / 512.
- R5: `upd_stb` is high for exactly one system clock per low half, in the cycle that lies `dly_cfg` clocks after the falling edge. A delay of 0 means the first low cycle.
- R6: If `dly_cfg` is greater than `div_cfg`, `upd_stb` instead fires in the last low cycle, one system clock before the rising edge.
- R7: `smp_stb` is high for exactly one system clock per high half, in the first high cycle. It never fires while `bus_clk` is low.
- R8: The divider and delay in use are captured only while idle. Changes made while `run_en` is high take effect only after the generator has gone idle and been started again.
- R9: One system clock after `run_en` falls, `bus_clk` is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Request for bus activity |
| div_cfg | input | 8 | Half-period divider; each half lasts div_cfg+1 system clocks |
| dly_cfg | input | 3 | Data-update delay after the falling edge, in system clocks |
| bus_clk | output | 1 | Serial bus clock, idles high |
| upd_stb | output | 1 | One-cycle strobe: the data line may change |
| smp_stb | output | 1 | One-cycle strobe: sample the data line on the rising edge |

## Verification
Every output comes straight from the registers that one system-clock edge updates. A change on `run_en` therefore shows up on `bus_clk` and on the strobes in the cycle after the edge that sees it, with no further pipeline stage. The bench drives inputs on the falling system-clock edge and samples on the next falling edge. It numbers the cycles from the starting edge and computes, for every cycle, the level of `bus_clk` (from cycle index divided by `div_cfg`+1) and the expected strobe pulses, then compares them with the outputs. The stop-and-hold checks are sampled exactly one cycle after `run_en` drops.

// File: rtl/busclk_gen.sv
module busclk_gen #(
  parameter int DIV_W = 8,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             bus_clk,
  output logic             upd_stb,
  output logic             smp_stb
);

  localparam int PAD_W = DIV_W - DLY_W;

  logic             run_q;
  logic             clk_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] dly_q;
  logic [DIV_W-1:0] dly_ext;
  logic [DIV_W-1:0] upd_pos;
  logic             half_end;

  assign dly_ext  = {{PAD_W{1'b0}}, dly_q};
  assign upd_pos  = (dly_ext > div_q) ? div_q : dly_ext;
  assign half_end = (cnt_q == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      clk_q <= 1'b1;
      cnt_q <= '0;
      div_q <= '0;
      dly_q <= '0;
    end else if (!run_en) begin
      run_q <= 1'b0;
      clk_q <= 1'b1;
      cnt_q <= '0;
      div_q <= div_cfg;
      dly_q <= dly_cfg;
    end else if (!run_q) begin
      run_q <= 1'b1;
      clk_q <= 1'b0;
      cnt_q <= '0;
      div_q <= div_cfg;
      dly_q <= dly_cfg;
    end else if (half_end) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bus_clk = clk_q;
  assign upd_stb = run_q && !clk_q && (cnt_q == upd_pos);
  assign smp_stb = run_q &&  clk_q && (cnt_q == '0);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_en) |-> (bus_clk && !upd_stb && !smp_stb));

  assert_start_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !run_q) |=> !bus_clk);

  assert_half_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && run_q && !half_end) |=> $stable(bus_clk));

  assert_upd_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> !bus_clk);

  assert_smp_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (bus_clk && !$past(bus_clk)));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && run_q) |=> ($stable(div_q) && $stable(dly_q)));

endmodule

// File: tb/busclk_gen_bench.sv
module busclk_gen_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [7:0] div_cfg = 8'd0;
  logic [2:0] dly_cfg = 3'd0;
  logic       bus_clk, upd_stb, smp_stb;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // each entry: {dly[10:8], div[7:0]}
  localparam logic [10:0] VEC [9] = '{
    {3'd0, 8'd0}, {3'd1, 8'd0}, {3'd1, 8'd1}, {3'd2, 8'd3}, {3'd7, 8'd3},
    {3'd0, 8'd5}, {3'd3, 8'd7}, {3'd4, 8'd4}, {3'd7, 8'd255}
  };

  always #(CLK_P/2) clk = ~clk;

  busclk_gen u_busclk_gen (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_cfg(div_cfg),
    .dly_cfg(dly_cfg), .bus_clk(bus_clk), .upd_stb(upd_stb), .smp_stb(smp_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(bus_clk === 1'b1, req, bus_clk, 1);
    chk(upd_stb === 1'b0, req, upd_stb, 0);
    chk(smp_stb === 1'b0, req, smp_stb, 0);
  endtask

  task automatic chk_cycle(input int n, input int dv, input int dl);
    int ph;
    int eff;
    bit eclk, eupd, esmp;
    ph   = n % (dv + 1);
    eff  = (dl > dv) ? dv : dl;
    eclk = ((n / (dv + 1)) % 2) != 0;
    eupd = !eclk && (ph == eff);
    esmp = eclk && (ph == 0);
    chk(bus_clk === eclk, (n == 0) ? "R3" : "R4", bus_clk, eclk);
    chk(upd_stb === eupd, (dl > dv) ? "R6" : "R5", upd_stb, eupd);
    chk(smp_stb === esmp, "R7", smp_stb, esmp);
  endtask

  task automatic start_run(input int dv, input int dl);
    run_en = 1'b0; div_cfg = 8'(dv); dly_cfg = 3'(dl);
    @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic follow(input int dv, input int dl, input int n0, input int n1);
    for (int n = n0; n < n1; n++) begin
      chk_cycle(n, dv, dl);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 5; k++) begin
      div_cfg = 8'(k * 37); dly_cfg = 3'(k);
      @(negedge clk);
      chk_idle("R2");
    end

    for (int v = 0; v < 9; v++) begin
      start_run(int'(VEC[v][7:0]), int'(VEC[v][10:8]));
      follow(int'(VEC[v][7:0]), int'(VEC[v][10:8]), 0, 4 * (int'(VEC[v][7:0]) + 1));
    end

    // R8: change config mid-run, old values must persist
    start_run(2, 1);
    follow(2, 1, 0, 10);
    div_cfg = 8'd6; dly_cfg = 3'd4;
    follow(2, 1, 10, 30);

    // R9: stop
    run_en = 1'b0;
    @(negedge clk);
    chk_idle("R9");

    // R8: new config takes effect after idle
    start_run(6, 4);
    follow(6, 4, 0, 28);

    // R9: stop in the middle of a low half
    start_run(4, 2);
    follow(4, 2, 0, 2);
    run_en = 1'b0;
    @(negedge clk);
    chk_idle("R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule